// File: doc/BRIEF.md
# T1 Line Density and Loss Monitor

This block watches the recovered receive bit stream of a T1 line. A strobe marks each valid line bit. From those bits the block keeps three status outputs, each with its own rules for setting and clearing. The first output is a digital loss-of-signal level. It is raised by a long run of zeros, and the run length is chosen by a control input. It is dropped only when the bit stream shows enough ones again. The second output is a pulse-density violation flag. It toggles each time the stream begins to break the ones-density rules. The third output is an all-ones (AIS) indication, which is judged once per fixed window of bits.

All state advances only on cycles where the bit strobe is high. In every other cycle the block holds its state. Each output changes in the clock cycle after the bit that decides it. Framing, clock recovery and any register access are handled elsewhere on the chip.

Top module: `t1_density_mon`

## Requirements
- R1: After reset, `los` is 0, `pdv` is 0 and `ais` is 1. The density history is treated as all ones, and the AIS window starts at the first strobed bit.
- R2: In a cycle with `bit_en` low, no counter, history or output changes, whatever `rx_bit` and `short_sel` are.
- R3: With `short_sel` = 0, `los` rises on the strobed bit that completes a run of 192 consecutive zeros. A run of 191 zeros leaves it low.
- R4: With `short_sel` = 1, `los` rises on the strobed bit that completes a run of 32 consecutive zeros. A run of 31 zeros leaves it low.
- R5: While `los` is high, the strobed bits are grouped into back-to-back windows of 386 bits. The first window starts with the bit after `los` rose. At the end of a window `los` falls if that window held more than 48 ones; otherwise it stays high.
- R6: A run of 16 consecutive zeros is a density violation.
- R7: For every N from 1 to 23, fewer than N ones among the latest 8(N+1) strobed bits (the current bit included) is a density violation.
- R8: `pdv` inverts on each strobed bit at which a violation (R6 or R7) is present and was absent at the previous strobed bit. A violation that lasts over several bits causes only one inversion.
- R9: The strobed bits are grouped into back-to-back windows of 4632 bits. At the end of each window `ais` becomes 1 if that window held fewer than 5 zeros, and 0 otherwise. `ais` changes at no other time.
- R10: Each output keeps its old value until the rising clock edge that samples the deciding bit. It shows the new value in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High for one cycle per valid received line bit |
| rx_bit | input | 1 | Received line bit, sampled when `bit_en` is high |
| short_sel | input | 1 | Loss run length: 1 selects 32 zeros, 0 selects 192 zeros |
| los | output | 1 | Digital loss-of-signal level |
| pdv | output | 1 | Density violation flag, inverted on each new violation |
| ais | output | 1 | All-ones indication, updated at each window end |

## Verification
A zero-run count that is off by even one bit moves the `los` rising edge, or the first `pdv` inversion, by that bit. This shows at the port within one cycle of the 16th, 32nd or 192nd zero. A window counter or ones total that drifts in the loss-clear logic or the N-of-8(N+1) history shows in a different way. It either drops `los` at a different window end, or it makes `pdv` invert on a density pattern that sits just past the 1-in-8 boundary. Such faults can take up to 386 bits, or up to 192 bits of history, to appear. A miscounted AIS window shows only at the next 4632-bit boundary. For that reason the stimulus runs several full windows with 4 zeros and with 5 zeros.

// File: rtl/t1dm_pkg.sv
package t1dm_pkg;

  // Length in bits of the density window checked for a given N
  function automatic int unsigned win_len(input int unsigned n);
    return 8 * (n + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Zero-run length that raises loss, picked by the select input
  function automatic int unsigned run_limit(input logic short_sel,
                                            input int unsigned long_run,
                                            input int unsigned short_run);
    return short_sel ? short_run : long_run;
  endfunction

endpackage

// File: rtl/t1dm_zero_run.sv
module t1dm_zero_run #(
  parameter int unsigned MAX_RUN = 192,
  localparam int unsigned RUN_W  = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  output logic [RUN_W-1:0] run_nxt
);

  logic [RUN_W-1:0] run_q;

  // Zero count including the bit now presented, saturating at MAX_RUN
  always_comb begin
    if (rx_bit)                         run_nxt = '0;
    else if (run_q == RUN_W'(MAX_RUN))  run_nxt = run_q;
    else                                run_nxt = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (bit_en) run_q <= run_nxt;
  end

  AST_RUN_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(run_q)); // R2

endmodule

// File: rtl/t1dm_los_ctl.sv
module t1dm_los_ctl #(
  parameter int unsigned LONG_RUN     = 192,
  parameter int unsigned SHORT_RUN    = 32,
  parameter int unsigned RUN_W        = 8,
  parameter int unsigned CLR_WIN      = 386,
  parameter int unsigned CLR_MIN_ONES = 48,
  localparam int unsigned CW = $clog2(CLR_WIN),
  localparam int unsigned OW = $clog2(CLR_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             short_sel,
  input  logic [RUN_W-1:0] run_nxt,
  output logic             los
);

  logic          los_q;
  logic [CW-1:0] win_cnt;
  logic [OW-1:0] ones_cnt, ones_nxt;
  logic [RUN_W-1:0] thr;
  logic          run_hit, win_end, dens_ok;

  assign thr      = RUN_W'(t1dm_pkg::run_limit(short_sel, LONG_RUN, SHORT_RUN));
  assign run_hit  = bit_en && (run_nxt >= thr);
  assign win_end  = bit_en && los_q && (win_cnt == CW'(CLR_WIN - 1));
  assign ones_nxt = ones_cnt + OW'(rx_bit);
  assign dens_ok  = ones_nxt > OW'(CLR_MIN_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q    <= 1'b0;
      win_cnt  <= '0;
      ones_cnt <= '0;
    end else if (!los_q) begin
      if (run_hit) begin
        los_q    <= 1'b1;
        win_cnt  <= '0;
        ones_cnt <= '0;
      end
    end else if (bit_en) begin
      if (win_end) begin
        win_cnt  <= '0;
        ones_cnt <= '0;
        if (dens_ok) los_q <= 1'b0;
      end else begin
        win_cnt  <= win_cnt + CW'(1);
        ones_cnt <= ones_nxt;
      end
    end
  end

  assign los = los_q;

  AST_LOS_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> $past(bit_en && !rx_bit)); // R3
  AST_LOS_FALL_AT_WIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_q) |-> $past(win_end)); // R5
  AST_LOS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(los_q)); // R2
  AST_LOS_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(CLR_WIN - 1)); // R5

endmodule

// File: rtl/t1dm_pdv.sv
module t1dm_pdv #(
  parameter int unsigned NMAX     = 23,
  parameter int unsigned ZERO_RUN = 16,
  parameter int unsigned RUN_W    = 8,
  localparam int unsigned HIST    = t1dm_pkg::win_len(NMAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [RUN_W-1:0] run_nxt,
  output logic             pdv
);

  logic [HIST-1:0] hist_q;
  logic [NMAX-1:0] sparse_vec;
  logic            zero_hit, viol_now, viol_q, onset, pdv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist_q <= '1;
    else if (bit_en) hist_q <= {hist_q[HIST-2:0], rx_bit};
  end

  // One running ones count per window length 8(N+1)
  for (genvar n = 1; n <= NMAX; n++) begin : g_win
    localparam int unsigned L  = t1dm_pkg::win_len(n);
    localparam int unsigned CW = $clog2(L + 1);
    logic [CW-1:0] cnt_q, cnt_nxt;

    assign cnt_nxt = cnt_q + CW'(rx_bit) - CW'(hist_q[L-1]);
    assign sparse_vec[n-1] = cnt_nxt < CW'(n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= CW'(L);
      else if (bit_en) cnt_q <= cnt_nxt;
    end

    AST_PDV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(L)); // R7
  end

  assign zero_hit = run_nxt >= RUN_W'(ZERO_RUN);
  assign viol_now = zero_hit || (|sparse_vec);
  assign onset    = bit_en && viol_now && !viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      pdv_q  <= 1'b0;
    end else if (bit_en) begin
      viol_q <= viol_now;
      if (onset) pdv_q <= ~pdv_q;
    end
  end

  assign pdv = pdv_q;

  AST_PDV_ONSET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pdv_q) |-> $past(onset)); // R8
  AST_PDV_RUN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !rx_bit && run_nxt == RUN_W'(ZERO_RUN) && !viol_q) |=> !$stable(pdv_q)); // R6

endmodule

// File: rtl/t1dm_ais.sv
module t1dm_ais #(
  parameter int unsigned WIN       = 4632,
  parameter int unsigned MAX_ZEROS = 5,
  localparam int unsigned CW = $clog2(WIN),
  localparam int unsigned ZW = $clog2(MAX_ZEROS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic ais
);

  logic [CW-1:0] win_cnt;
  logic [ZW-1:0] zcnt, zcnt_nxt;
  logic          win_end, ais_q;

  assign win_end  = bit_en && (win_cnt == CW'(WIN - 1));
  assign zcnt_nxt = (!rx_bit && zcnt != ZW'(MAX_ZEROS)) ? zcnt + ZW'(1) : zcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      zcnt    <= '0;
      ais_q   <= 1'b1;
    end else if (bit_en) begin
      if (win_end) begin
        win_cnt <= '0;
        zcnt    <= '0;
        ais_q   <= zcnt_nxt < ZW'(MAX_ZEROS);
      end else begin
        win_cnt <= win_cnt + CW'(1);
        zcnt    <= zcnt_nxt;
      end
    end
  end

  assign ais = ais_q;

  AST_AIS_WIN_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais_q) |-> $past(win_end)); // R9
  AST_AIS_ZERO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    zcnt <= ZW'(MAX_ZEROS)); // R9
  AST_AIS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(win_cnt)); // R2

endmodule

// File: rtl/t1_density_mon.sv
module t1_density_mon #(
  parameter int unsigned LONG_RUN     = 192,
  parameter int unsigned SHORT_RUN    = 32,
  parameter int unsigned LOS_WIN      = 386,
  parameter int unsigned LOS_MIN_ONES = 48,
  parameter int unsigned PDV_RUN      = 16,
  parameter int unsigned PDV_NMAX     = 23,
  parameter int unsigned AIS_WIN      = 4632,
  parameter int unsigned AIS_ZEROS    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic short_sel,
  output logic los,
  output logic pdv,
  output logic ais
);

  localparam int unsigned RUN_MAX = t1dm_pkg::max3(LONG_RUN, SHORT_RUN, PDV_RUN);
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_nxt;

  t1dm_zero_run #(.MAX_RUN(RUN_MAX)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .run_nxt(run_nxt)
  );

  t1dm_los_ctl #(
    .LONG_RUN(LONG_RUN), .SHORT_RUN(SHORT_RUN), .RUN_W(RUN_W),
    .CLR_WIN(LOS_WIN), .CLR_MIN_ONES(LOS_MIN_ONES)
  ) u_los (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .short_sel(short_sel), .run_nxt(run_nxt), .los(los)
  );

  t1dm_pdv #(.NMAX(PDV_NMAX), .ZERO_RUN(PDV_RUN), .RUN_W(RUN_W)) u_pdv (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .run_nxt(run_nxt), .pdv(pdv)
  );

  t1dm_ais #(.WIN(AIS_WIN), .MAX_ZEROS(AIS_ZEROS)) u_ais (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .ais(ais)
  );

endmodule

// File: tb/t1_density_mon_test.sv
`timescale 1ns/1ps
module t1_density_mon_test;

  logic clk = 1'b0;
  logic rst_n, bit_en, rx_bit, short_sel;
  logic los, pdv, ais;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  t1_density_mon uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .short_sel(short_sel), .los(los), .pdv(pdv), .ais(ais)
  );

  // Segment: [19:18] kind (0 zeros, 1 ones, 2 one every P, 3 zero every P),
  // [17:14] period P, [13] short_sel, [12:0] length in bits
  localparam int NSEG = 16;
  localparam logic [19:0] SEG [NSEG] = '{
    {2'd1, 4'd0,  1'b0, 13'd300},
    {2'd0, 4'd0,  1'b1, 13'd40},
    {2'd2, 4'd4,  1'b1, 13'd800},
    {2'd0, 4'd0,  1'b0, 13'd200},
    {2'd2, 4'd9,  1'b0, 13'd900},
    {2'd2, 4'd8,  1'b0, 13'd400},
    {2'd2, 4'd2,  1'b0, 13'd800},
    {2'd1, 4'd0,  1'b0, 13'd6000},
    {2'd1, 4'd0,  1'b0, 13'd5000},
    {2'd3, 4'd15, 1'b0, 13'd60},
    {2'd1, 4'd0,  1'b0, 13'd4500},
    {2'd3, 4'd15, 1'b0, 13'd75},
    {2'd1, 4'd0,  1'b0, 13'd4500},
    {2'd0, 4'd0,  1'b1, 13'd31},
    {2'd1, 4'd0,  1'b1, 13'd20},
    {2'd0, 4'd0,  1'b0, 13'd191}
  };

  // Reference model state
  int   m_run, m_lw, m_lo, m_aw, m_az;
  logic m_los, m_pdv, m_ais, m_vq;
  logic mh [192];
  string los_tag, pdv_tag;

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_lw = 0; m_lo = 0; m_aw = 0; m_az = 0;
    m_los = 0; m_pdv = 0; m_ais = 1; m_vq = 0;
    for (int i = 0; i < 192; i++) mh[i] = 1'b1;
  endtask

  task automatic model_step(input logic b, input logic sel);
    int s;
    logic viol, by_run;
    // loss of signal
    m_run = b ? 0 : m_run + 1;
    if (!m_los) begin
      los_tag = sel ? "R4" : "R3";
      if (!b && m_run >= (sel ? 32 : 192)) begin
        m_los = 1; m_lw = 0; m_lo = 0;
      end
    end else begin
      los_tag = "R5";
      m_lo += int'(b);
      m_lw++;
      if (m_lw == 386) begin
        if (m_lo > 48) m_los = 0;
        m_lw = 0; m_lo = 0;
      end
    end
    // density: explicit sums over the bit history
    for (int i = 191; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = b;
    by_run = (m_run >= 16);
    viol = by_run;
    s = 0;
    for (int i = 0; i < 192; i++) begin
      s += int'(mh[i]);
      if ((i + 1) % 8 == 0 && (i + 1) >= 16 && s < (i + 1) / 8 - 1) viol = 1;
    end
    pdv_tag = (viol && !m_vq) ? (by_run ? "R6" : "R7") : "R8";
    if (viol && !m_vq) m_pdv = ~m_pdv;
    m_vq = viol;
    // AIS window
    m_aw++;
    if (!b) m_az++;
    if (m_aw == 4632) begin
      m_ais = (m_az < 5);
      m_aw = 0; m_az = 0;
    end
  endtask

  // Called just after a rising edge; presents one bit for one cycle
  task automatic send_bit(input logic b, input logic sel);
    short_sel = sel; rx_bit = b; bit_en = 1'b1;
    #3;
    chk("R10", los, m_los, "los before edge");
    chk("R10", pdv, m_pdv, "pdv before edge");
    @(posedge clk); #1;
    bit_en = 1'b0;
    model_step(b, sel);
    chk(los_tag, los, m_los, "los");
    chk(pdv_tag, pdv, m_pdv, "pdv");
    chk("R9", ais, m_ais, "ais");
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; short_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    model_reset();
    chk("R1", los, 1'b0, "los after reset");
    chk("R1", pdv, 1'b0, "pdv after reset");
    chk("R1", ais, 1'b1, "ais after reset");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [19:0] sg;
    logic b;
    apply_reset();

    // Table walk
    for (int s = 0; s < NSEG; s++) begin
      sg = SEG[s];
      for (int i = 0; i < int'(sg[12:0]); i++) begin
        case (sg[19:18])
          2'd0: b = 1'b0;
          2'd1: b = 1'b1;
          2'd2: b = (i % int'(sg[17:14]) == 0);
          default: b = (i % int'(sg[17:14]) != 0);
        endcase
        send_bit(b, sg[13]);
      end
    end
    chk("R3", los, 1'b0, "191 zeros with long threshold");

    // Idle cycles must not extend a zero run or move any output
    apply_reset();
    for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b1);
    chk("R6", pdv, 1'b1, "16-zero run toggled pdv once");
    for (int i = 0; i < 40; i++) begin
      rx_bit = 1'b0; short_sel = 1'b1;
      @(posedge clk); #1;
      chk("R2", los, 1'b0, "los during idle");
      chk("R2", pdv, 1'b1, "pdv during idle");
      chk("R2", ais, 1'b1, "ais during idle");
    end
    for (int i = 0; i < 11; i++) send_bit(1'b0, 1'b1);
    chk("R4", los, 1'b0, "31 strobed zeros");
    send_bit(1'b0, 1'b1);
    chk("R4", los, 1'b1, "32 strobed zeros");
    chk("R8", pdv, 1'b1, "no second toggle in same run");

    // Reset mid-alarm returns to the reset state
    apply_reset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule